// File: doc/BRIEF.md
# Serial PHY Lane Timing Calculator

This block turns a lane data rate, given in Mbps, and a lane-type flag into the counts that program one lane of a high-speed serial transmitter PHY. Most counts are measured in byte-clock cycles. The byte clock runs at one eighth of the bit rate. The three bus-turnaround counts are measured in escape-clock cycles. The escape clock is the byte clock divided by the smallest integer that brings it down to 20 MHz or below. Each computed count is the smallest number of clock periods that covers a minimum duration in nanoseconds.

The HS-prepare, HS-trail and HS-zero counts do not come from arithmetic. They come from an internal table of rate bands. HS-zero has one value for the clock lane and a different value for the data lanes. Clock-post and clock-pre exist only on the clock lane. Both wakeup counts are constants.

Software or a sequencer sets the rate and the lane type, then pulses start. The block works through its divisions one at a time on a single shared shift-subtract divider. It then raises done and keeps every result steady until the next start. Any count too large for its field is clipped to the field maximum, and an overflow flag is raised.

Top module: `lane_tmg_calc`

## Requirements
- R1: A start pulse while idle latches the rate and lane type, raises busy_o and clears done_o on the next cycle. When the results are ready, busy_o falls and done_o rises. A start pulse while busy_o is high is ignored, and the run in progress finishes with the values it first latched.
- R2: The band is the first one whose upper edge is at or above the rate. The edges, in order, are 110, 150, 200, 250, 300, 400, 500, 600, 700, 800 and 1000 Mbps, and a rate above 1000 uses the last band. The band sets hs_prep_o and hs_trail_o. It also sets hs_zero_o, using the clock-lane value when clk_lane_i=1 and the data-lane value when it is 0.
- R3: With byteclk = rate·125000 Hz, hs_exit_o = ceil(120 ns · byteclk / 1e9).
- R4: lpx_o = ceil(60 ns · byteclk / 1e9), reduced by 2 only when that value exceeds 2.
- R5: With UI = round(1000/rate) ns, a clock lane gives clk_post_o = ceil((70+52·UI)·byteclk/1e9) and clk_pre_o = ceil(8·UI·byteclk/1e9). A data lane gives 0 on both outputs.
- R6: With div = ceil(byteclk/20e6) and escclk = floor(byteclk/div), ta_go_o, ta_sure_o and ta_wait_o are ceil(ns·escclk/1e9) for 240, 120 and 300 ns respectively.
- R7: At done, wake_hi_o = 3 and wake_lo_o = 255.
- R8: A count larger than its field (lpx 6 bits, hs_exit 5 bits, clk_post and clk_pre 4 bits, turnaround counts 6 bits) is output as the field maximum and sets ovf_o. A start accepted while idle clears ovf_o. Clock-post and clock-pre never set ovf_o on a data lane.
- R9: While done_o is high and no start arrives, every result output and ovf_o stay unchanged.
- R10: A rate of 0 is treated as 1 Mbps.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| rate_i | input | RATE_W (11) | Lane rate in Mbps |
| clk_lane_i | input | 1 | 1 selects the clock lane, 0 a data lane |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Results valid |
| ovf_o | output | 1 | A result was clipped |
| lpx_o | output | 6 | LPX count |
| hs_prep_o | output | 7 | HS-prepare value |
| hs_zero_o | output | 6 | HS-zero value |
| hs_trail_o | output | 7 | HS-trail value |
| hs_exit_o | output | 5 | HS-exit count |
| clk_post_o | output | 4 | Clock-post count |
| clk_pre_o | output | 4 | Clock-pre count |
| wake_hi_o | output | 2 | Wakeup high count |
| wake_lo_o | output | 8 | Wakeup low count |
| ta_go_o | output | 6 | Turnaround go count |
| ta_sure_o | output | 6 | Turnaround sure count |
| ta_wait_o | output | 6 | Turnaround wait count |

## Verification
The bench aims at rates on either side of the 110 Mbps band edge and at rates above the last band. A lookup that used a strict comparison, or that did not stop at the last band, would report the wrong prepare, zero or trail values. Rates of 1 and 2047 Mbps test the extremes of the UI rounding, of the escape divider and of LPX near its subtract-by-two threshold. A wrong rounding or a missing threshold shows up as a count off by one or two. The 1000 and 2047 Mbps clock-lane runs overflow clock-post. A run that follows them checks that the flag clears, and a data-lane run checks that clock-post and clock-pre are zero. A design that lets a mid-run start restart the run would report the second rate instead of the first.

// File: rtl/lane_tmg_pkg.sv
package lane_tmg_pkg;
  localparam int LPX_W   = 6;
  localparam int PREP_W  = 7;
  localparam int ZERO_W  = 6;
  localparam int TRAIL_W = 7;
  localparam int EXIT_W  = 5;
  localparam int CPOST_W = 4;
  localparam int CPRE_W  = 4;
  localparam int WKH_W   = 2;
  localparam int WKL_W   = 8;
  localparam int TA_W    = 6;
  localparam int NBANDS  = 11;
  localparam int SEL_W   = $clog2(NBANDS);

  typedef struct packed {
    logic [PREP_W-1:0]  prep;
    logic [ZERO_W-1:0]  clk_zero;
    logic [ZERO_W-1:0]  dat_zero;
    logic [TRAIL_W-1:0] trail;
  } band_t;

  function automatic int unsigned band_edge(input int idx);
    case (idx)
      0: return 110;   1: return 150;  2: return 200;  3: return 250;
      4: return 300;   5: return 400;  6: return 500;  7: return 600;
      8: return 700;   9: return 800;  default: return 1000;
    endcase
  endfunction

  function automatic band_t band_val(input int idx);
    case (idx)
      0: return '{7'h20, 6'h16, 6'h02, 7'h22};
      1: return '{7'h06, 6'h16, 6'h03, 7'h45};
      2: return '{7'h18, 6'h17, 6'h04, 7'h0b};
      3: return '{7'h05, 6'h17, 6'h05, 7'h16};
      4: return '{7'h51, 6'h18, 6'h06, 7'h2c};
      5: return '{7'h64, 6'h19, 6'h07, 7'h33};
      6: return '{7'h20, 6'h1b, 6'h07, 7'h4e};
      7: return '{7'h6a, 6'h1d, 6'h08, 7'h3a};
      8: return '{7'h3e, 6'h1e, 6'h08, 7'h6a};
      9: return '{7'h21, 6'h1f, 6'h09, 7'h29};
      default: return '{7'h09, 6'h20, 6'h09, 7'h27};
    endcase
  endfunction
endpackage

// File: rtl/lane_tmg_div.sv
module lane_tmg_div #(
  parameter int W = 34
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    rem_sh, diff;
  logic          ge;

  assign rem_sh = {rem_q, quo_q[W-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};
  assign ge     = rem_sh >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0; dvd_q <= '0;
      cnt_q <= '0; done_q <= 1'b0;
    end else if (start_i) begin
      rem_q <= '0; quo_q <= dvd_i; dvs_q <= dvs_i; dvd_q <= dvd_i;
      cnt_q <= CW'(W); done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= ge ? diff[W-1:0] : rem_sh[W-1:0];
      quo_q  <= {quo_q[W-2:0], ge};
      cnt_q  <= cnt_q - CW'(1);
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R3 R4 R5 R6: every count rests on an exact quotient
  div_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q} + {{W{1'b0}}, rem_q})
                 == {{W{1'b0}}, dvd_q}) && (rem_q < dvs_q));
endmodule

// File: rtl/lane_tmg_band.sv
module lane_tmg_band
  import lane_tmg_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0]  rate_i,
  input  logic               clk_lane_i,
  output logic [PREP_W-1:0]  prep_o,
  output logic [ZERO_W-1:0]  zero_o,
  output logic [TRAIL_W-1:0] trail_o
);
  logic [NBANDS-1:0] hit;
  logic [SEL_W-1:0]  sel;
  band_t             bv;

  for (genvar g = 0; g < NBANDS; g++) begin : g_edge
    assign hit[g] = 32'(rate_i) <= band_edge(g);
  end

  // first band at or above the rate wins; default is the last band
  always_comb begin
    sel = SEL_W'(NBANDS - 1);
    for (int i = NBANDS - 1; i >= 0; i--)
      if (hit[i]) sel = SEL_W'(i);
  end

  assign bv      = band_val(int'(sel));
  assign prep_o  = bv.prep;
  assign trail_o = bv.trail;
  assign zero_o  = clk_lane_i ? bv.clk_zero : bv.dat_zero;
endmodule

// File: rtl/lane_tmg_calc.sv
module lane_tmg_calc
  import lane_tmg_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int W      = 34
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic               clk_lane_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               ovf_o,
  output logic [LPX_W-1:0]   lpx_o,
  output logic [PREP_W-1:0]  hs_prep_o,
  output logic [ZERO_W-1:0]  hs_zero_o,
  output logic [TRAIL_W-1:0] hs_trail_o,
  output logic [EXIT_W-1:0]  hs_exit_o,
  output logic [CPOST_W-1:0] clk_post_o,
  output logic [CPRE_W-1:0]  clk_pre_o,
  output logic [WKH_W-1:0]   wake_hi_o,
  output logic [WKL_W-1:0]   wake_lo_o,
  output logic [TA_W-1:0]    ta_go_o,
  output logic [TA_W-1:0]    ta_sure_o,
  output logic [TA_W-1:0]    ta_wait_o
);
  localparam int       NSTEPS = 10;
  localparam int       SW     = $clog2(NSTEPS);
  localparam [W-1:0]   BYTE_D = W'(8000);        // ns * rate / BYTE_D = byte cycles
  localparam [W-1:0]   NS_D   = W'(1000000000);
  localparam [W-1:0]   HZ_PER = W'(125000);      // byte clock Hz per Mbps

  logic [RATE_W-1:0] rate_q;
  logic              lane_q, busy_q, done_q, ovf_q, issue_q;
  logic [SW-1:0]     step_q;
  logic [W-1:0]      ui_q, ediv_q, eclk_q;
  logic [W-1:0]      dvd, dvs, quo, rate_w, lpx_v;
  logic              div_done;
  logic [PREP_W-1:0]  b_prep;
  logic [ZERO_W-1:0]  b_zero;
  logic [TRAIL_W-1:0] b_trail;

  function automatic logic over_f(input logic [W-1:0] v, input int w);
    return v > W'((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [W-1:0] clip(input logic [W-1:0] v, input int w);
    return over_f(v, w) ? W'((64'd1 << w) - 64'd1) : v;
  endfunction

  assign rate_w = W'(rate_q);
  assign lpx_v  = (quo > W'(2)) ? quo - W'(2) : quo;

  always_comb begin
    dvs = BYTE_D;
    case (step_q)
      SW'(0):  begin dvd = W'(1000) + (rate_w >> 1);          dvs = rate_w;   end
      SW'(1):  begin dvd = rate_w + W'(159);                  dvs = W'(160);  end
      SW'(2):  begin dvd = rate_w * HZ_PER;                   dvs = ediv_q;   end
      SW'(3):  dvd = W'(120) * rate_w + BYTE_D - W'(1);
      SW'(4):  dvd = W'(60) * rate_w + BYTE_D - W'(1);
      SW'(5):  dvd = (W'(70) + W'(52) * ui_q) * rate_w + BYTE_D - W'(1);
      SW'(6):  dvd = W'(8) * ui_q * rate_w + BYTE_D - W'(1);
      SW'(7):  begin dvd = W'(240) * eclk_q + NS_D - W'(1);   dvs = NS_D;     end
      SW'(8):  begin dvd = W'(120) * eclk_q + NS_D - W'(1);   dvs = NS_D;     end
      default: begin dvd = W'(300) * eclk_q + NS_D - W'(1);   dvs = NS_D;     end
    endcase
  end

  lane_tmg_div #(.W(W)) i_div (
    .clk_i, .rst_ni, .start_i(issue_q), .dvd_i(dvd), .dvs_i(dvs),
    .done_o(div_done), .quo_o(quo)
  );

  lane_tmg_band #(.RATE_W(RATE_W)) i_band (
    .rate_i(rate_q), .clk_lane_i(lane_q),
    .prep_o(b_prep), .zero_o(b_zero), .trail_o(b_trail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0; lane_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      ovf_q <= 1'b0; issue_q <= 1'b0; step_q <= '0;
      ui_q <= '0; ediv_q <= '0; eclk_q <= '0;
      lpx_o <= '0; hs_prep_o <= '0; hs_zero_o <= '0; hs_trail_o <= '0;
      hs_exit_o <= '0; clk_post_o <= '0; clk_pre_o <= '0;
      wake_hi_o <= '0; wake_lo_o <= '0;
      ta_go_o <= '0; ta_sure_o <= '0; ta_wait_o <= '0;
    end else begin
      issue_q <= 1'b0;
      if (start_i && !busy_q) begin
        rate_q  <= (rate_i == '0) ? RATE_W'(1) : rate_i;
        lane_q  <= clk_lane_i;
        busy_q  <= 1'b1;
        done_q  <= 1'b0;
        ovf_q   <= 1'b0;
        step_q  <= '0;
        issue_q <= 1'b1;
      end else if (busy_q && div_done) begin
        case (step_q)
          SW'(0): ui_q   <= quo;
          SW'(1): ediv_q <= quo;
          SW'(2): eclk_q <= quo;
          SW'(3): begin
            hs_exit_o <= EXIT_W'(clip(quo, EXIT_W));
            ovf_q     <= ovf_q | over_f(quo, EXIT_W);
          end
          SW'(4): begin
            lpx_o <= LPX_W'(clip(lpx_v, LPX_W));
            ovf_q <= ovf_q | over_f(lpx_v, LPX_W);
          end
          SW'(5): begin
            clk_post_o <= lane_q ? CPOST_W'(clip(quo, CPOST_W)) : '0;
            ovf_q      <= ovf_q | (lane_q & over_f(quo, CPOST_W));
          end
          SW'(6): begin
            clk_pre_o <= lane_q ? CPRE_W'(clip(quo, CPRE_W)) : '0;
            ovf_q     <= ovf_q | (lane_q & over_f(quo, CPRE_W));
          end
          SW'(7): begin
            ta_go_o <= TA_W'(clip(quo, TA_W));
            ovf_q   <= ovf_q | over_f(quo, TA_W);
          end
          SW'(8): begin
            ta_sure_o <= TA_W'(clip(quo, TA_W));
            ovf_q     <= ovf_q | over_f(quo, TA_W);
          end
          default: begin
            ta_wait_o <= TA_W'(clip(quo, TA_W));
            ovf_q     <= ovf_q | over_f(quo, TA_W);
          end
        endcase
        if (step_q == SW'(NSTEPS - 1)) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          hs_prep_o  <= b_prep;
          hs_zero_o  <= b_zero;
          hs_trail_o <= b_trail;
          wake_hi_o  <= WKH_W'(3);
          wake_lo_o  <= WKL_W'(255);
        end else begin
          step_q  <= step_q + SW'(1);
          issue_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  // R1
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o);
  // R1
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable({lpx_o, hs_prep_o, hs_zero_o, hs_trail_o, hs_exit_o,
      clk_post_o, clk_pre_o, wake_hi_o, wake_lo_o, ta_go_o, ta_sure_o, ta_wait_o, ovf_o}));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !(start_i && !busy_o) |=> ovf_o);
endmodule

// File: tb/test_lane_tmg_calc.sv
module test_lane_tmg_calc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] rate_i = '0;
  logic        clk_lane_i = 1'b0;
  logic        busy_o, done_o, ovf_o;
  logic [5:0]  lpx_o, hs_zero_o, ta_go_o, ta_sure_o, ta_wait_o;
  logic [6:0]  hs_prep_o, hs_trail_o;
  logic [4:0]  hs_exit_o;
  logic [3:0]  clk_post_o, clk_pre_o;
  logic [1:0]  wake_hi_o;
  logic [7:0]  wake_lo_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  lane_tmg_calc i_lane_tmg_calc (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint cdiv(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  function automatic longint satv(input longint v, input int w, inout bit o);
    longint m = (64'd1 << w) - 1;
    if (v > m) begin o = 1; return m; end
    return v;
  endfunction

  task automatic exp_check(input int rate, input bit lane, input string tag);
    longint r, bc, ui, ed, ec, e_exit, e_lpx, e_post, e_pre, e_go, e_sure, e_wait;
    int band;
    bit ov = 0;
    int edges[11] = '{110, 150, 200, 250, 300, 400, 500, 600, 700, 800, 1000};
    int prep[11]  = '{'h20, 'h06, 'h18, 'h05, 'h51, 'h64, 'h20, 'h6a, 'h3e, 'h21, 'h09};
    int czero[11] = '{'h16, 'h16, 'h17, 'h17, 'h18, 'h19, 'h1b, 'h1d, 'h1e, 'h1f, 'h20};
    int dzero[11] = '{'h02, 'h03, 'h04, 'h05, 'h06, 'h07, 'h07, 'h08, 'h08, 'h09, 'h09};
    int trail[11] = '{'h22, 'h45, 'h0b, 'h16, 'h2c, 'h33, 'h4e, 'h3a, 'h6a, 'h29, 'h27};
    r  = (rate == 0) ? 1 : rate;   // R10
    bc = r * 125000;
    ui = (1000 + r / 2) / r;
    ed = cdiv(bc, 20000000);
    ec = bc / ed;
    e_exit = satv(cdiv(120 * bc, 1000000000), 5, ov);
    e_lpx  = cdiv(60 * bc, 1000000000);
    if (e_lpx > 2) e_lpx -= 2;
    e_lpx  = satv(e_lpx, 6, ov);
    e_post = 0; e_pre = 0;
    if (lane) begin
      e_post = satv(cdiv((70 + 52 * ui) * bc, 1000000000), 4, ov);
      e_pre  = satv(cdiv(8 * ui * bc, 1000000000), 4, ov);
    end
    e_go   = satv(cdiv(240 * ec, 1000000000), 6, ov);
    e_sure = satv(cdiv(120 * ec, 1000000000), 6, ov);
    e_wait = satv(cdiv(300 * ec, 1000000000), 6, ov);
    band = 10;
    for (int i = 10; i >= 0; i--) if (r <= edges[i]) band = i;
    chk({tag, " R1 done"}, done_o, 1);
    chk({tag, " R2 hs_prep"}, hs_prep_o, prep[band]);
    chk({tag, " R2 hs_trail"}, hs_trail_o, trail[band]);
    chk({tag, " R2 hs_zero"}, hs_zero_o, lane ? czero[band] : dzero[band]);
    chk({tag, " R3 hs_exit"}, hs_exit_o, e_exit);
    chk({tag, " R4 lpx"}, lpx_o, e_lpx);
    chk({tag, " R5 clk_post"}, clk_post_o, e_post);
    chk({tag, " R5 clk_pre"}, clk_pre_o, e_pre);
    chk({tag, " R6 ta_go"}, ta_go_o, e_go);
    chk({tag, " R6 ta_sure"}, ta_sure_o, e_sure);
    chk({tag, " R6 ta_wait"}, ta_wait_o, e_wait);
    chk({tag, " R7 wake_hi"}, wake_hi_o, 3);
    chk({tag, " R7 wake_lo"}, wake_lo_o, 255);
    chk({tag, " R8 ovf"}, ovf_o, ov);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 5000) begin @(negedge clk_i); n++; end
    if (!done_o) chk({tag, " R1 timeout"}, 0, 1);
  endtask

  task automatic t_run(input int rate, input bit lane, input string tag);
    @(negedge clk_i);
    start_i = 1; rate_i = 11'(rate); clk_lane_i = lane;
    @(negedge clk_i);
    start_i = 0;
    chk({tag, " R1 busy"}, busy_o, 1);
    chk({tag, " R1 done clr"}, done_o, 0);
    wait_done(tag);
    exp_check(rate, lane, tag);
  endtask

  task automatic t_reset();
    chk("R11 busy", busy_o, 0);
    chk("R11 done", done_o, 0);
    chk("R11 ovf", ovf_o, 0);
    chk("R11 fields", {lpx_o, hs_prep_o, hs_zero_o, hs_trail_o, hs_exit_o, clk_post_o,
        clk_pre_o, wake_hi_o, wake_lo_o, ta_go_o, ta_sure_o, ta_wait_o} == '0, 1);
  endtask

  task automatic t_hold();
    logic [79:0] snap;
    snap = {ovf_o, lpx_o, hs_prep_o, hs_zero_o, hs_trail_o, hs_exit_o, clk_post_o,
            clk_pre_o, wake_hi_o, wake_lo_o, ta_go_o, ta_sure_o, ta_wait_o};
    rate_i = 11'd333; clk_lane_i = ~clk_lane_i;
    repeat (20) @(negedge clk_i);
    chk("R9 outputs held", snap == {ovf_o, lpx_o, hs_prep_o, hs_zero_o, hs_trail_o,
        hs_exit_o, clk_post_o, clk_pre_o, wake_hi_o, wake_lo_o, ta_go_o, ta_sure_o,
        ta_wait_o}, 1);
    chk("R9 done held", done_o, 1);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk_i);
    start_i = 1; rate_i = 11'd1000; clk_lane_i = 1;
    @(negedge clk_i);
    start_i = 0;
    repeat (5) @(negedge clk_i);
    start_i = 1; rate_i = 11'd120; clk_lane_i = 0;
    @(negedge clk_i);
    start_i = 0;
    chk("R1 still busy", busy_o, 1);
    wait_done("R1 ignore");
    exp_check(1000, 1, "R1 ignore");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_run(1, 1, "rate1 clk");
    t_run(110, 0, "rate110 data");
    t_run(111, 1, "rate111 clk");
    t_run(1000, 1, "rate1000 clk");
    t_run(450, 0, "rate450 data ovf clr");
    t_run(1500, 0, "rate1500 data");
    t_run(2047, 1, "rate2047 clk");
    t_hold();
    t_run(0, 1, "rate0 clk");
    t_run(800, 1, "rate800 clk");
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule